// File: doc/BRIEF.md
# Memory Lock-Bit Access Guard

This block sits between the programming command path and the on-chip memory arrays. It decides whether each read or program request may go ahead. Each request names a target space: code, data, user signature, factory signature, configuration fuses, or the lock bytes themselves. Each request also carries an origin flag that separates the external programmer from in-application software. The guard keeps two lock bytes, works out a protection level from them, and answers every request one cycle later with a grant or a deny. A denied read returns a fixed zero byte in place of the array data.

Lock bytes start erased at FFh. A lock write can only clear bits. The only way back to FFh is a chip erase. The erase also raises a one-cycle pulse that tells the array controller to clear code and data. The guard drives a debug-enable output, which drops at the highest protection level. Reset is a power-on reset. The lock registers stand in for nonvolatile cells, and a fresh device has both bytes at FFh.

Top module: `lockguard_top`

## Requirements
- R1: After reset, rsp_valid is 0, dbg_en is 1 and both lock bytes read back as FFh.
- R2: A request presented with req_valid high at a clock edge is answered with rsp_valid high for exactly one cycle after that edge. With no request, rsp_valid stays 0.
- R3: With both lock bytes at FFh, every external request is granted. The exceptions are writes to the factory signature and requests to an unused space code. Space codes are: 0 code, 1 data, 2 user signature, 3 factory signature, 4 fuses, 5 lock bytes; 6 and 7 are unused. Origin is 0 for external and 1 for software. req_write is 1 for program and 0 for read.
- R4: A lock byte counts as programmed when it holds any value other than FFh. With lock byte 0 programmed and lock byte 1 at FFh, every external write is denied, including lock-byte writes, and external reads are granted.
- R5: With lock byte 1 programmed, whatever lock byte 0 holds, external writes are denied and external reads of code and data are denied. External reads of user signature, factory signature, fuses and lock bytes are granted, and dbg_en is 0. Otherwise dbg_en is 1.
- R6: Software-origin writes to any space except the factory signature are granted, and software reads are granted, at every protection level.
- R7: A denied request and every write response return rsp_rdata = 00h. A granted array read returns req_rdata as sampled with the request. A granted read of space 5 returns lock byte req_sel (0 or 1).
- R8: A granted write to space 5 sets lock byte req_sel to its old value AND req_wdata. A denied lock write leaves it unchanged.
- R9: A chip_erase pulse sets both lock bytes to FFh at that edge, and erase_arrays is high for the following cycle only. A request in the same cycle as chip_erase is denied.
- R10: Factory-signature writes and any request to space 6 or 7 are denied from either origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 program, 0 read |
| req_space | input | 3 | Target space code |
| req_origin | input | 1 | 0 external programmer, 1 in-application software |
| req_sel | input | 1 | Lock byte select for space 5 |
| req_wdata | input | 8 | Write data (used for lock-byte writes) |
| req_rdata | input | 8 | Array read data for the current request |
| chip_erase | input | 1 | Chip erase pulse |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request allowed |
| rsp_rdata | output | 8 | Read result or 00h |
| erase_arrays | output | 1 | One-cycle pulse to clear code and data arrays |
| dbg_en | output | 1 | On-chip debug permitted |

## Verification
The assertions assume that requests are single-cycle and are sampled at the clock edge. They also assume chip_erase is a pulse, and that req_sel is 0 or 1 whenever space 5 is addressed. The bench drives every input on the falling edge and holds it for exactly one cycle, so these hold. The bench sweeps every space, origin and direction at each protection level. Lock writes inside the sweeps carry FFh, so the sweep never changes the level it is testing. Moves between levels are made only by deliberate lock writes and erases.

// File: rtl/lg_pkg.sv
// Package: shared encodings for the lock-bit access guard.
// Assumes 3-bit space codes and a 1-bit origin flag.
package lg_pkg;
    localparam logic [2:0] SP_CODE = 3'd0;
    localparam logic [2:0] SP_DATA = 3'd1;
    localparam logic [2:0] SP_USIG = 3'd2;
    localparam logic [2:0] SP_FSIG = 3'd3;
    localparam logic [2:0] SP_FUSE = 3'd4;
    localparam logic [2:0] SP_LOCK = 3'd5;

    localparam logic ORG_EXT = 1'b0;
    localparam logic ORG_SW  = 1'b1;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd1,
        LVL_NOPROG = 2'd2,
        LVL_SEALED = 2'd3
    } lvl_e;
endpackage

// File: rtl/lg_lock_store.sv
// Lock store: holds the lock bytes and applies clear-only writes and erase.
// Assumes erase has priority over a write in the same cycle. Reset loads
// the fresh-device value (all ones).
module lg_lock_store #(
    parameter int DATA_W    = 8,
    parameter int NUM_LOCKS = 2,
    parameter int SEL_W     = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             erase_i,
    input  logic                             wr_en_i,
    input  logic [SEL_W-1:0]                 wr_sel_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [NUM_LOCKS-1:0][DATA_W-1:0] lock_q
);
    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        // Update one lock byte: erase sets it to ones, a write may only clear bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[g] <= '1;
            end else if (erase_i) begin
                lock_q[g] <= '1;
            end else if (wr_en_i && (wr_sel_i == SEL_W'(g))) begin
                lock_q[g] <= lock_q[g] & wr_data_i;
            end
        end

        // R8: without an erase, no lock bit goes from 0 to 1.
        a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            !erase_i |=> ((lock_q[g] & ~$past(lock_q[g])) == '0));

        // R9: an erase leaves the byte fully erased.
        a_r9_erase_restores: assert property (@(posedge clk) disable iff (!rst_n)
            erase_i |=> (lock_q[g] == '1));
    end
endmodule

// File: rtl/lg_policy.sv
// Policy: derives the protection level from the lock bytes and decides
// grant or deny for the current request. Purely combinational.
// Assumes at least two lock bytes; byte 0 blocks programming and byte 1
// additionally seals array reads and debug.
module lg_policy
    import lg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_LOCKS = 2
) (
    input  logic [NUM_LOCKS-1:0][DATA_W-1:0] lock_q,
    input  logic                             valid_i,
    input  logic                             write_i,
    input  logic [2:0]                       space_i,
    input  logic                             origin_i,
    input  logic                             erase_i,
    output logic                             grant_o,
    output logic                             lock_wr_o,
    output lvl_e                             level_o,
    output logic                             dbg_en_o
);
    logic prog0;
    logic prog1;
    logic space_ok;
    logic array_space;

    // Classify lock bytes: any cleared bit counts as programmed.
    always_comb begin
        prog0 = (lock_q[0] != '1);
        prog1 = (lock_q[1] != '1);
    end

    // Map programmed bytes to a protection level; byte 1 alone also seals.
    always_comb begin
        if (prog1)      level_o = LVL_SEALED;
        else if (prog0) level_o = LVL_NOPROG;
        else            level_o = LVL_OPEN;
    end

    // Debug is permitted below the sealed level.
    always_comb dbg_en_o = (level_o != LVL_SEALED);

    // Decide grant from direction, origin, space and level.
    always_comb begin
        space_ok    = (space_i <= SP_LOCK);
        array_space = (space_i == SP_CODE) || (space_i == SP_DATA);
        grant_o     = 1'b0;
        if (valid_i && !erase_i && space_ok) begin
            if (write_i) begin
                if (space_i == SP_FSIG)     grant_o = 1'b0;
                else if (origin_i == ORG_SW) grant_o = 1'b1;
                else                        grant_o = (level_o == LVL_OPEN);
            end else begin
                grant_o = !(array_space && (origin_i == ORG_EXT) &&
                            (level_o == LVL_SEALED));
            end
        end
    end

    // Forward granted lock-byte writes to the store.
    always_comb lock_wr_o = grant_o && write_i && (space_i == SP_LOCK);
endmodule

// File: rtl/lg_resp_stage.sv
// Response stage: registers grant, read data and the erase pulse.
// Assumes the decision and data arrive in the request cycle; the answer
// appears one cycle later.
module lg_resp_stage
    import lg_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  DENY_VALUE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [2:0]        space_i,
    input  logic              grant_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic [DATA_W-1:0] lock_data_i,
    input  logic              erase_i,
    output logic              rsp_valid_o,
    output logic              rsp_grant_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              erase_pulse_o
);
    localparam logic [DATA_W-1:0] DENY_W = DATA_W'(DENY_VALUE);

    logic [DATA_W-1:0] data_next;

    // Pick the returned byte: fixed value for denied or write, else source.
    always_comb begin
        if (!grant_i || write_i)     data_next = DENY_W;
        else if (space_i == SP_LOCK) data_next = lock_data_i;
        else                         data_next = array_data_i;
    end

    // Register the response and the erase pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o   <= 1'b0;
            rsp_grant_o   <= 1'b0;
            rsp_rdata_o   <= DENY_W;
            erase_pulse_o <= 1'b0;
        end else begin
            rsp_valid_o   <= valid_i;
            rsp_grant_o   <= valid_i && grant_i;
            rsp_rdata_o   <= valid_i ? data_next : DENY_W;
            erase_pulse_o <= erase_i;
        end
    end

    // R2: every request is answered in the next cycle, and only then.
    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> rsp_valid_o);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !rsp_valid_o);

    // R7: a denied response never carries array data.
    a_r7_deny_value: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !grant_i) |=> (rsp_rdata_o == DENY_W));

    // R9: erase pulse lasts one cycle for a one-cycle request.
    a_r9_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_i && !$past(erase_i)) |=> erase_pulse_o);
endmodule

// File: rtl/lockguard_top.sv
// Lock-bit access guard top: joins lock store, policy and response stage.
// Assumes single-cycle requests and a power-on reset; lock registers stand
// in for nonvolatile cells.
module lockguard_top
    import lg_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter logic [7:0] DENY_VALUE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_space,
    input  logic              req_origin,
    input  logic              req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_rdata,
    input  logic              chip_erase,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              erase_arrays,
    output logic              dbg_en
);
    localparam int NUM_LOCKS = 2;
    localparam int SEL_W     = $clog2(NUM_LOCKS);

    logic [NUM_LOCKS-1:0][DATA_W-1:0] lock_q;
    logic              grant;
    logic              lock_wr;
    lvl_e              level;
    logic [DATA_W-1:0] lock_sel_data;

    lg_lock_store #(.DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS), .SEL_W(SEL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_i   (chip_erase),
        .wr_en_i   (lock_wr),
        .wr_sel_i  (req_sel),
        .wr_data_i (req_wdata),
        .lock_q    (lock_q)
    );

    lg_policy #(.DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)) u_policy (
        .lock_q    (lock_q),
        .valid_i   (req_valid),
        .write_i   (req_write),
        .space_i   (req_space),
        .origin_i  (req_origin),
        .erase_i   (chip_erase),
        .grant_o   (grant),
        .lock_wr_o (lock_wr),
        .level_o   (level),
        .dbg_en_o  (dbg_en)
    );

    // Select the addressed lock byte for lock-space reads.
    always_comb lock_sel_data = lock_q[req_sel];

    lg_resp_stage #(.DATA_W(DATA_W), .DENY_VALUE(DENY_VALUE)) u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (req_valid),
        .write_i       (req_write),
        .space_i       (req_space),
        .grant_i       (grant),
        .array_data_i  (req_rdata),
        .lock_data_i   (lock_sel_data),
        .erase_i       (chip_erase),
        .rsp_valid_o   (rsp_valid),
        .rsp_grant_o   (rsp_grant),
        .rsp_rdata_o   (rsp_rdata),
        .erase_pulse_o (erase_arrays)
    );

    // R5: an external array read at the sealed level is refused.
    a_r5_sealed_array_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_origin == ORG_EXT) &&
         ((req_space == SP_CODE) || (req_space == SP_DATA)) &&
         (lock_q[1] != '1)) |=> (rsp_valid && !rsp_grant));

    // R4: no external write passes once any lock byte is programmed.
    a_r4_ext_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_origin == ORG_EXT) &&
         (level != LVL_OPEN)) |=> !rsp_grant);

    // R6: software writes outside the factory signature always pass.
    a_r6_sw_write_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_origin == ORG_SW) && !chip_erase &&
         (req_space <= SP_LOCK) && (req_space != SP_FSIG)) |=> rsp_grant);

    // R10: factory signature is never programmed.
    a_r10_fsig_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_space == SP_FSIG)) |=> !rsp_grant);
endmodule

// File: tb/lockguard_top_bench.sv
`timescale 1ns/1ps
module lockguard_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_origin = 1'b0, req_sel = 1'b0;
    logic [2:0] req_space = 3'd0;
    logic [7:0] req_wdata = 8'hFF, req_rdata = 8'h00;
    logic       chip_erase = 1'b0;
    logic       rsp_valid, rsp_grant, erase_arrays, dbg_en;
    logic [7:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] m0 = 8'hFF, m1 = 8'hFF;

    always #2.5 clk = ~clk;

    lockguard_top u_lockguard_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_origin(req_origin), .req_sel(req_sel),
        .req_wdata(req_wdata), .req_rdata(req_rdata), .chip_erase(chip_erase),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_rdata(rsp_rdata),
        .erase_arrays(erase_arrays), .dbg_en(dbg_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_grant(input int sp, input bit org, input bit wr);
        bit p0 = (m0 != 8'hFF);
        bit p1 = (m1 != 8'hFF);
        if (sp > 5) return 1'b0;
        if (wr) begin
            if (sp == 3) return 1'b0;
            if (org) return 1'b1;
            return !(p0 || p1);
        end
        if ((sp == 0 || sp == 1) && !org && p1) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string tag_for(input int sp, input bit org, input bit wr);
        if (sp > 5 || (wr && sp == 3)) return "R10";
        if (org) return "R6";
        if (m1 != 8'hFF) return "R5";
        if (m0 != 8'hFF) return "R4";
        return "R3";
    endfunction

    // One request: drive at falling edge, check at the next falling edge.
    task automatic issue(input int sp, input bit org, input bit wr, input bit sel,
                         input logic [7:0] wd, input logic [7:0] rd);
        bit g;
        logic [7:0] ed;
        string t;
        g = exp_grant(sp, org, wr);
        t = tag_for(sp, org, wr);
        if (!g || wr) ed = 8'h00;
        else if (sp == 5) ed = sel ? m1 : m0;
        else ed = rd;
        req_valid = 1'b1; req_space = 3'(sp); req_origin = org; req_write = wr;
        req_sel = sel; req_wdata = wd; req_rdata = rd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check({t, " grant"}, {31'd0, rsp_grant}, {31'd0, g});
        check("R7 rdata", {24'd0, rsp_rdata}, {24'd0, ed});
        if (g && wr && sp == 5) begin
            if (sel) m1 = m1 & wd; else m0 = m0 & wd;
        end
    endtask

    task automatic read_lock(input bit sel, input string tag);
        logic [7:0] e;
        e = sel ? m1 : m0;
        issue(5, 1'b0, 1'b0, sel, 8'hFF, 8'h00);
        check({tag, " lock readback"}, {24'd0, rsp_rdata}, {24'd0, e});
    endtask

    task automatic sweep();
        for (int sp = 0; sp < 8; sp++)
            for (int o = 0; o < 2; o++)
                for (int w = 0; w < 2; w++)
                    issue(sp, o[0], w[0], 1'b0, 8'hFF, 8'h80 | 8'(sp * 8 + o * 2 + w));
        check("R5 dbg_en", {31'd0, dbg_en}, {31'd0, m1 == 8'hFF});
    endtask

    task automatic erase_chip();
        chip_erase = 1'b1;
        req_valid = 1'b1; req_space = 3'd0; req_origin = 1'b0; req_write = 1'b0;
        req_rdata = 8'h5A;
        @(negedge clk);
        chip_erase = 1'b0; req_valid = 1'b0;
        check("R9 same-cycle deny", {31'd0, rsp_grant}, 32'd0);
        check("R9 pulse high", {31'd0, erase_arrays}, 32'd1);
        m0 = 8'hFF; m1 = 8'hFF;
        @(negedge clk);
        check("R9 pulse ends", {31'd0, erase_arrays}, 32'd0);
        read_lock(1'b0, "R9");
        read_lock(1'b1, "R9");
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 dbg_en", {31'd0, dbg_en}, 32'd1);
        @(negedge clk);
        check("R2 idle", {31'd0, rsp_valid}, 32'd0);
        read_lock(1'b0, "R1");
        read_lock(1'b1, "R1");

        sweep();                                    // R3 open level
        issue(5, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);  // R8 program byte 0
        read_lock(1'b0, "R8");
        sweep();                                    // R4 no-program level
        issue(5, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);  // R4 denied lock write
        read_lock(1'b1, "R4");
        issue(5, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);  // R6 software lock write
        read_lock(1'b1, "R6");
        sweep();                                    // R5 sealed level
        erase_chip();                               // R9

        issue(5, 1'b0, 1'b1, 1'b1, 8'h0F, 8'h00);  // R5 byte 1 only
        read_lock(1'b1, "R5");
        sweep();
        erase_chip();

        issue(5, 1'b0, 1'b1, 1'b0, 8'h7F, 8'h00);  // R8 partial clear
        issue(5, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00);  // R8 cannot set bits
        read_lock(1'b0, "R8");
        sweep();
        @(negedge clk);
        check("R2 idle end", {31'd0, rsp_valid}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule